// File: doc/BRIEF.md
# DDR Command Turnaround Spacing Gate

This block sits between a DDR command scheduler and the memory command bus. It remembers the type (read or write) and chip select of the last command that went out, and it knows when the device has just come out of a powerdown state. From these it decides whether the command the scheduler is offering now may go out in this cycle. A command issues on a rising clock edge where `req_valid` and `grant` are both high.

Minimum spacing between commands is derived from the CAS latency, the write latency and the burst length. A small programmable number of extra clocks is added on top for each kind of transition. The CAS latency arrives in half-clock units, so the read-to-write spacing can round it up and the write-to-read spacing can round it down. Throughout, a gap of N clocks means that if a command issues at edge t, the next command may issue at edge t+N at the earliest.

Top module: `ddr_turnaround_gate`

## Requirements
- R1: After reset the history is clear, so the first request of either type to any chip select is granted in the same cycle it is offered.
- R2: A read that follows a read to the same chip select, or a write that follows a write to the same chip select, is spaced by BL/2 clocks. BL is 8 when `cfg_bl8`=1 and `cfg_ddr3`=1, and 4 otherwise.
- R3: A write that follows a read, on any chip select, is spaced by ceil(CL) − WL + BL/2 + 2 + `cfg_rtw_extra` clocks, where CL = `cfg_cl_half`/2.
- R4: A read that follows a write, on any chip select, is spaced by floor(CL) − ... specifically WL − floor(CL) + BL/2 + 1 + `cfg_wtr_extra` clocks.
- R5: A read that follows a read to a different chip select is spaced by 3 + `cfg_rr_extra` clocks, or by 5 + `cfg_rr_extra` when 8-beat bursts are in effect.
- R6: A write that follows a write to a different chip select is spaced by 2 + `cfg_ww_extra` clocks, or by 4 + `cfg_ww_extra` when 8-beat bursts are in effect.
- R7: With `cfg_ddr3`=0, `cfg_bl8` has no effect, and every gap uses the 4-beat values.
- R8: A one-cycle pulse on `apd_exit` blocks all commands for the following `cfg_apd_wait` clocks (0 to 7). A request is therefore first granted `cfg_apd_wait`+1 cycles after the pulse cycle.
- R9: A pulse on `ppd_exit` blocks all commands for the following `cfg_ppd_wait` clocks. Codes 1 to 15 give 1 to 15 clocks. Code 0 is illegal and is treated as 15 clocks.
- R10: When the R3 or R4 formula gives zero or a negative value, the gap is 1 clock, so the command may issue at the very next edge.
- R11: `grant` is low in any cycle in which `apd_exit` or `ppd_exit` is high. When both pulse together, the longer of the two waits applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ddr3 | input | 1 | 1 = DDR3 mode; 8-beat bursts are only honoured in this mode |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts requested |
| cfg_cl_half | input | CLW (5) | CAS latency in half clocks |
| cfg_wl | input | WLW (4) | Write latency in clocks |
| cfg_rtw_extra | input | 2 | Extra clocks for read-to-write |
| cfg_wtr_extra | input | 2 | Extra clocks for write-to-read |
| cfg_rr_extra | input | 2 | Extra clocks for read-to-read on a different chip select |
| cfg_ww_extra | input | 2 | Extra clocks for write-to-write on a different chip select |
| cfg_apd_wait | input | 3 | Clocks to wait after leaving active powerdown |
| cfg_ppd_wait | input | 4 | Clocks to wait after leaving precharge powerdown (0 = 15) |
| apd_exit | input | 1 | One-cycle pulse: the device has left active powerdown |
| ppd_exit | input | 1 | One-cycle pulse: the device has left precharge powerdown |
| req_valid | input | 1 | The scheduler offers a command |
| req_is_write | input | 1 | 1 = the offered command is a write, 0 = a read |
| req_cs | input | CSW (2) | Chip select of the offered command |
| grant | output | 1 | The offered command may issue at this edge |

## Verification
Two events can fall in the same cycle: a powerdown-exit pulse arriving while the scheduler holds a request, and the two powerdown-exit pulses arriving together. The bench drives each exit pulse with a request already held, and checks that the grant stays low in the pulse cycle. It then counts the cycles until the grant returns and compares that count with a wait computed from the programmed codes. For simultaneous pulses it checks that the larger of the two waits wins, including the case where the reserved code 0 becomes 15.

// File: rtl/ddr_turnaround_gate.sv
module ddr_turnaround_gate #(
  parameter int CLW  = 5,
  parameter int WLW  = 4,
  parameter int CSW  = 2,
  parameter int CNTW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_ddr3,
  input  logic           cfg_bl8,
  input  logic [CLW-1:0] cfg_cl_half,
  input  logic [WLW-1:0] cfg_wl,
  input  logic [1:0]     cfg_rtw_extra,
  input  logic [1:0]     cfg_wtr_extra,
  input  logic [1:0]     cfg_rr_extra,
  input  logic [1:0]     cfg_ww_extra,
  input  logic [2:0]     cfg_apd_wait,
  input  logic [3:0]     cfg_ppd_wait,
  input  logic           apd_exit,
  input  logic           ppd_exit,
  input  logic           req_valid,
  input  logic           req_is_write,
  input  logic [CSW-1:0] req_cs,
  output logic           grant
);

  localparam int EW = (CLW > WLW ? CLW : WLW) + 3;

  function automatic logic [CNTW-1:0] gap_less1(input logic signed [EW-1:0] v);
    return (v < 1) ? '0 : CNTW'(v - 1);
  endfunction

  logic                  burst8;
  logic [EW-1:0]         cl_h;
  logic signed [EW-1:0]  cl_up, cl_dn, wl_e, half_bl, rtw_raw, wtr_raw, rr_raw, ww_raw;
  logic [CNTW-1:0]       rtw_ld, wtr_ld, rr_ld, ww_ld, same_ld;

  assign burst8  = cfg_bl8 & cfg_ddr3;
  assign cl_h    = EW'(cfg_cl_half);
  assign cl_up   = signed'((cl_h + EW'(1)) >> 1);
  assign cl_dn   = signed'(cl_h >> 1);
  assign wl_e    = signed'(EW'(cfg_wl));
  assign half_bl = burst8 ? EW'(4) : EW'(2);
  assign rtw_raw = cl_up - wl_e + half_bl + EW'(2) + signed'(EW'(cfg_rtw_extra));
  assign wtr_raw = wl_e - cl_dn + half_bl + EW'(1) + signed'(EW'(cfg_wtr_extra));
  assign rr_raw  = (burst8 ? EW'(5) : EW'(3)) + signed'(EW'(cfg_rr_extra));
  assign ww_raw  = (burst8 ? EW'(4) : EW'(2)) + signed'(EW'(cfg_ww_extra));

  assign rtw_ld  = gap_less1(rtw_raw);
  assign wtr_ld  = gap_less1(wtr_raw);
  assign rr_ld   = gap_less1(rr_raw);
  assign ww_ld   = gap_less1(ww_raw);
  assign same_ld = gap_less1(half_bl);

  logic [CNTW-1:0] rd_same, rd_other, wr_same, wr_other;
  logic [3:0]      pd_rem, apd_ld, ppd_ld, pd_ld;
  logic [CSW-1:0]  last_cs;
  logic            same_cs, issue;
  logic [CNTW-1:0] sel_rem;

  assign apd_ld  = {1'b0, cfg_apd_wait};
  assign ppd_ld  = (cfg_ppd_wait == 4'd0) ? 4'd15 : cfg_ppd_wait;
  assign pd_ld   = ppd_exit ? ((apd_exit && apd_ld > ppd_ld) ? apd_ld : ppd_ld) : apd_ld;

  assign same_cs = (req_cs == last_cs);
  assign sel_rem = req_is_write ? (same_cs ? wr_same : wr_other)
                                : (same_cs ? rd_same : rd_other);
  assign grant   = (sel_rem == '0) && (pd_rem == 4'd0) && !apd_exit && !ppd_exit;
  assign issue   = req_valid && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_same  <= '0;
      rd_other <= '0;
      wr_same  <= '0;
      wr_other <= '0;
      last_cs  <= '0;
    end else if (issue) begin
      last_cs <= req_cs;
      if (req_is_write) begin
        wr_same  <= same_ld;
        wr_other <= ww_ld;
        rd_same  <= wtr_ld;
        rd_other <= wtr_ld;
      end else begin
        rd_same  <= same_ld;
        rd_other <= rr_ld;
        wr_same  <= rtw_ld;
        wr_other <= rtw_ld;
      end
    end else begin
      if (rd_same  != '0) rd_same  <= rd_same  - 1'b1;
      if (rd_other != '0) rd_other <= rd_other - 1'b1;
      if (wr_same  != '0) wr_same  <= wr_same  - 1'b1;
      if (wr_other != '0) wr_other <= wr_other - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    pd_rem <= 4'd0;
    else if (apd_exit || ppd_exit) pd_rem <= pd_ld;
    else if (pd_rem != 4'd0)       pd_rem <= pd_rem - 4'd1;
  end

  // R2
  rd_same_cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !req_is_write) |=> !(grant && !req_is_write && req_cs == $past(req_cs)));

  // R2
  wr_same_cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_is_write) |=> !(grant && req_is_write && req_cs == $past(req_cs)));

  // R9
  ppd_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppd_exit && cfg_ppd_wait == 4'd0) |=> (pd_rem == 4'd15));

  // R8
  pd_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_rem != 4'd0 && !apd_exit && !ppd_exit) |=> (pd_rem == $past(pd_rem) - 4'd1));

  // R11
  exit_cycle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apd_exit || ppd_exit) |-> !grant);

endmodule

// File: tb/test_ddr_turnaround_gate.sv
module test_ddr_turnaround_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ddr3 = 0, cfg_bl8 = 0;
  logic [4:0] cfg_cl_half = 5'd10;
  logic [3:0] cfg_wl = 4'd4;
  logic [1:0] cfg_rtw_extra = 0, cfg_wtr_extra = 0, cfg_rr_extra = 0, cfg_ww_extra = 0;
  logic [2:0] cfg_apd_wait = 0;
  logic [3:0] cfg_ppd_wait = 1;
  logic apd_exit = 0, ppd_exit = 0, req_valid = 0, req_is_write = 0;
  logic [1:0] req_cs = 0;
  logic grant;
  int runs = 0, fails = 0;
  int seed_init;

  always #10 clk = ~clk;

  ddr_turnaround_gate i_ddr_turnaround_gate (
    .clk(clk), .rst_n(rst_n), .cfg_ddr3(cfg_ddr3), .cfg_bl8(cfg_bl8),
    .cfg_cl_half(cfg_cl_half), .cfg_wl(cfg_wl),
    .cfg_rtw_extra(cfg_rtw_extra), .cfg_wtr_extra(cfg_wtr_extra),
    .cfg_rr_extra(cfg_rr_extra), .cfg_ww_extra(cfg_ww_extra),
    .cfg_apd_wait(cfg_apd_wait), .cfg_ppd_wait(cfg_ppd_wait),
    .apd_exit(apd_exit), .ppd_exit(ppd_exit), .req_valid(req_valid),
    .req_is_write(req_is_write), .req_cs(req_cs), .grant(grant));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(input bit pw, input bit nw, input bit same);
    int b8, hb, g;
    b8 = (cfg_bl8 && cfg_ddr3) ? 1 : 0;
    hb = b8 ? 4 : 2;
    if (pw == nw) begin
      if (same) g = hb;
      else if (pw) g = (b8 ? 4 : 2) + int'(cfg_ww_extra);
      else g = (b8 ? 5 : 3) + int'(cfg_rr_extra);
    end else if (!pw) g = (int'(cfg_cl_half) + 1) / 2 - int'(cfg_wl) + hb + 2 + int'(cfg_rtw_extra);
    else g = int'(cfg_wl) - int'(cfg_cl_half) / 2 + hb + 1 + int'(cfg_wtr_extra);
    return (g < 1) ? 1 : g;
  endfunction

  function automatic string gap_tag(input bit pw, input bit nw, input bit same);
    if (pw == nw) return same ? "R2" : (pw ? "R6" : "R5");
    return pw ? "R4" : "R3";
  endfunction

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic trial_gap(input bit pw, input bit nw, input bit same, input string tag);
    logic [1:0] c0, c1;
    int k, e;
    idle(40);
    c0 = 2'($urandom % 4);
    c1 = same ? c0 : (c0 ^ 2'(1 + $urandom % 3));
    req_valid = 1; req_is_write = pw; req_cs = c0;
    #2 check(grant === 1'b1, "R1 idle grant", int'(grant), 1);
    @(posedge clk);
    @(negedge clk);
    req_is_write = nw; req_cs = c1;
    k = 1;
    #2;
    while (!grant && k < 64) begin
      @(negedge clk); #2; k++;
    end
    e = exp_gap(pw, nw, same);
    check(k == e, tag, k, e);
    @(posedge clk);
    idle(0);
  endtask

  task automatic trial_pd(input bit a, input bit p);
    int k, e, ea, ep;
    idle(40);
    req_valid = 1; req_is_write = 1'($urandom % 2); req_cs = 2'($urandom % 4);
    apd_exit = a; ppd_exit = p;
    #2 check(grant === 1'b0, "R11 exit cycle", int'(grant), 0);
    @(negedge clk);
    apd_exit = 0; ppd_exit = 0;
    k = 1;
    #2;
    while (!grant && k < 64) begin
      @(negedge clk); #2; k++;
    end
    ea = a ? int'(cfg_apd_wait) : 0;
    ep = p ? ((cfg_ppd_wait == 0) ? 15 : int'(cfg_ppd_wait)) : 0;
    e = ((ea > ep) ? ea : ep) + 1;
    check(k == e, (a && p) ? "R11 both exits" : (a ? "R8" : "R9"), k, e);
    @(posedge clk);
    idle(0);
  endtask

  task automatic rand_cfg();
    cfg_ddr3 = 1'($urandom % 2); cfg_bl8 = 1'($urandom % 2);
    cfg_cl_half = 5'(6 + $urandom % 17); cfg_wl = 4'(2 + $urandom % 9);
    cfg_rtw_extra = 2'($urandom); cfg_wtr_extra = 2'($urandom);
    cfg_rr_extra = 2'($urandom); cfg_ww_extra = 2'($urandom);
    cfg_apd_wait = 3'($urandom); cfg_ppd_wait = 4'($urandom);
  endtask

  task automatic finish_report();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_report();
  end

  initial begin
    seed_init = $urandom(32'd771);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: first commands after reset
    req_valid = 1; req_is_write = 0; req_cs = 2'd3;
    #2 check(grant === 1'b1, "R1 read after reset", int'(grant), 1);
    req_is_write = 1;
    #1 check(grant === 1'b1, "R1 write after reset", int'(grant), 1);
    idle(2);

    // R10 clamp: read-to-write
    cfg_ddr3 = 0; cfg_bl8 = 0; cfg_cl_half = 5'd6; cfg_wl = 4'd10; cfg_rtw_extra = 0;
    trial_gap(0, 1, 0, "R10 rtw clamp");
    // R10 clamp: write-to-read
    cfg_cl_half = 5'd22; cfg_wl = 4'd2; cfg_wtr_extra = 0;
    trial_gap(1, 0, 1, "R10 wtr clamp");
    // R7: bl8 ignored outside DDR3
    cfg_ddr3 = 0; cfg_bl8 = 1; cfg_rr_extra = 0; cfg_ww_extra = 0;
    trial_gap(0, 0, 0, "R7 rr ddr2");
    trial_gap(1, 1, 1, "R7 ww same ddr2");
    // DDR3 8-beat
    cfg_ddr3 = 1; cfg_bl8 = 1; cfg_rr_extra = 2'd3; cfg_ww_extra = 2'd1;
    trial_gap(0, 0, 0, "R5 rr bl8");
    trial_gap(1, 1, 0, "R6 ww bl8");
    trial_gap(0, 0, 1, "R2 rd same bl8");
    // odd CL rounding
    cfg_cl_half = 5'd11; cfg_wl = 4'd5; cfg_rtw_extra = 2'd2; cfg_wtr_extra = 2'd1;
    trial_gap(0, 1, 0, "R3 odd cl");
    trial_gap(1, 0, 0, "R4 odd cl");
    // powerdown exits
    cfg_apd_wait = 3'd0; trial_pd(1, 0);
    cfg_apd_wait = 3'd7; trial_pd(1, 0);
    cfg_ppd_wait = 4'd0; trial_pd(0, 1);
    cfg_ppd_wait = 4'd1; trial_pd(0, 1);
    cfg_apd_wait = 3'd6; cfg_ppd_wait = 4'd3; trial_pd(1, 1);
    cfg_apd_wait = 3'd2; cfg_ppd_wait = 4'd0; trial_pd(1, 1);

    for (int i = 0; i < 160; i++) begin
      bit pw, nw, sm;
      rand_cfg();
      pw = 1'($urandom % 2); nw = 1'($urandom % 2); sm = 1'($urandom % 2);
      trial_gap(pw, nw, sm, gap_tag(pw, nw, sm));
    end
    for (int i = 0; i < 40; i++) begin
      bit a, p;
      rand_cfg();
      a = 1'($urandom % 2); p = 1'($urandom % 2);
      if (!a && !p) a = 1;
      trial_pd(a, p);
    end
    finish_report();
  end
endmodule